// File: doc/BRIEF.md
# Pipeline Interlock and Branch Stall Controller

This block is the combinational steering logic for a five-stage in-order pipeline made of fetch, decode, execute, memory and write-back stages. In every cycle it gives each pipe register one of three modes. Transfer loads the next state. Hold keeps the current state. Bubble clears the state to zero, and an all-zero state acts as a NOP.

The pipeline has no forwarding paths. When the instruction in decode reads a register that an older instruction in execute or memory will still write, decode and fetch are frozen and a bubble goes into execute. Conditional branches are resolved late, in the memory stage. While a branch sits in decode or execute, fetch is frozen and decode is filled with bubbles. When memory reports the outcome, a taken branch also squashes the instruction held in fetch, while a not-taken branch lets that instruction go on. The pipe registers, the register file and the ALU are not part of this block.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: Modes are encoded as transfer = 2'b00, hold = 2'b01 and bubble = 2'b10. With no hazard, no branch in decode or execute and no taken branch reported, all five stages transfer.
- R2: If decode source A matches the destination of a valid, writing instruction in execute, fetch and decode hold and execute gets a bubble.
- R3: A match against the destination of a valid, writing instruction in memory has the same effect as R2.
- R4: Decode source B causes an interlock only when `id_reads_b` is 1. With the flag at 0, a match on B alone leaves every stage in transfer.
- R5: A source equal to register index ZERO_REG (31 by default) never causes an interlock, even when a destination matches it.
- R6: A destination counts only when both its valid flag and its writes flag are 1. Otherwise a match has no effect.
- R7: While a conditional branch is in decode or execute, and no taken branch is reported, fetch holds, decode gets a bubble and execute transfers.
- R8: When memory reports a taken branch, decode gets a bubble and fetch, execute, memory and write-back transfer. This overrides R2, R3 and R7.
- R9: When memory reports a not-taken branch and no other condition applies, all stages transfer. Over one branch's passage, decode therefore gets 3 bubbles when the branch is taken and 2 when it is not.
- R10: When an interlock and a branch in decode or execute coincide, the interlock wins. Decode holds and is never bubbled in the same cycle.
- R11: The memory and write-back stages always transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | Source A register index of the decode instruction |
| id_src_b | input | REG_W | Source B register index of the decode instruction |
| id_reads_b | input | 1 | The decode instruction reads source B (register-register form) |
| ex_dst | input | REG_W | Destination register of the execute instruction |
| ex_valid | input | 1 | Execute holds a live instruction |
| ex_writes | input | 1 | The execute instruction writes a register |
| mem_dst | input | REG_W | Destination register of the memory instruction |
| mem_valid | input | 1 | Memory holds a live instruction |
| mem_writes | input | 1 | The memory instruction writes a register |
| br_in_id | input | 1 | A conditional branch is in decode |
| br_in_ex | input | 1 | A conditional branch is in execute |
| mem_br_taken | input | 1 | The branch in memory resolved taken |
| if_mode | output | 2 | Mode for the fetch pipe register |
| id_mode | output | 2 | Mode for the decode pipe register |
| ex_mode | output | 2 | Mode for the execute pipe register |
| mem_mode | output | 2 | Mode for the memory pipe register |
| wb_mode | output | 2 | Mode for the write-back pipe register |

## Verification
Every mode is a pure function of the inputs in the same cycle, so each result is due in the cycle its stimulus is applied and not a cycle later. The driver changes inputs one time unit after a rising edge and queues the expected five modes. The monitor pops and compares them at the following falling edge, which keeps every comparison inside the cycle it belongs to. The branch-cost check spans three such cycles, with the branch in decode, then in execute, then resolving in memory. It counts decode bubbles seen by the monitor and reads the total after the third falling edge.

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl #(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_reads_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_valid,
  input  logic             ex_writes,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_valid,
  input  logic             mem_writes,
  input  logic             br_in_id,
  input  logic             br_in_ex,
  input  logic             mem_br_taken,
  output logic [1:0]       if_mode,
  output logic [1:0]       id_mode,
  output logic [1:0]       ex_mode,
  output logic [1:0]       mem_mode,
  output logic [1:0]       wb_mode
);
  localparam logic [1:0] XFER = 2'b00;
  localparam logic [1:0] HOLD = 2'b01;
  localparam logic [1:0] BUBL = 2'b10;
  localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

  logic ex_live, mem_live, hit_a, hit_b, interlock, br_wait;

  assign ex_live  = ex_valid & ex_writes;
  assign mem_live = mem_valid & mem_writes;

  assign hit_a = (id_src_a != ZR) &
                 ((ex_live & (ex_dst == id_src_a)) | (mem_live & (mem_dst == id_src_a)));
  assign hit_b = id_reads_b & (id_src_b != ZR) &
                 ((ex_live & (ex_dst == id_src_b)) | (mem_live & (mem_dst == id_src_b)));

  assign interlock = hit_a | hit_b;
  assign br_wait   = br_in_id | br_in_ex;

  always_comb begin
    if_mode = XFER;
    id_mode = XFER;
    ex_mode = XFER;
    if (mem_br_taken) begin
      id_mode = BUBL;
    end else if (interlock) begin
      if_mode = HOLD;
      id_mode = HOLD;
      ex_mode = BUBL;
    end else if (br_wait) begin
      if_mode = HOLD;
      id_mode = BUBL;
    end
  end

  assign mem_mode = XFER;
  assign wb_mode  = XFER;

  always_comb begin
    assert_taken_flush_R8: assert (!mem_br_taken || (id_mode == BUBL && if_mode == XFER && ex_mode == XFER))
      else $error("taken branch did not flush decode");
    assert_hold_chain_R2: assert (id_mode != HOLD || (if_mode == HOLD && ex_mode == BUBL))
      else $error("decode held without fetch hold and execute bubble");
    assert_zero_reg_R5: assert (!(id_src_a == ZR && (id_src_b == ZR || !id_reads_b) && !br_wait && !mem_br_taken)
                                || (if_mode == XFER && id_mode == XFER && ex_mode == XFER))
      else $error("zero register caused a stall");
    assert_no_dead_write_R6: assert (ex_live || mem_live || br_wait || mem_br_taken
                                     || (if_mode == XFER && id_mode == XFER && ex_mode == XFER))
      else $error("stall without any live writer or branch");
    assert_tail_flows_R11: assert (mem_mode == XFER && wb_mode == XFER)
      else $error("memory or write-back not transferring");
    assert_ex_never_held_R10: assert (ex_mode != HOLD)
      else $error("execute held");
  end
endmodule

// File: tb/test_pipe_stall_ctrl.sv
module test_pipe_stall_ctrl;
  localparam logic [1:0] XF = 2'b00, HD = 2'b01, BB = 2'b10;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [4:0] src_a = 0, src_b = 0, exd = 0, memd = 0;
  logic rb = 0, exv = 0, exw = 0, memv = 0, memw = 0, bid = 0, bex = 0, tk = 0;
  logic [1:0] m_if, m_id, m_ex, m_mem, m_wb;

  pipe_stall_ctrl i_pipe_stall_ctrl (
    .id_src_a(src_a), .id_src_b(src_b), .id_reads_b(rb),
    .ex_dst(exd), .ex_valid(exv), .ex_writes(exw),
    .mem_dst(memd), .mem_valid(memv), .mem_writes(memw),
    .br_in_id(bid), .br_in_ex(bex), .mem_br_taken(tk),
    .if_mode(m_if), .id_mode(m_id), .ex_mode(m_ex),
    .mem_mode(m_mem), .wb_mode(m_wb));

  logic [9:0] exp_q[$];
  string      tag_q[$];
  int compared = 0, mismatched = 0, id_bubbles = 0;

  always @(negedge clk) begin
    if (m_id == BB) id_bubbles++;
    if (exp_q.size() > 0) begin
      logic [9:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {m_if, m_id, m_ex, m_mem, m_wb};
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s: actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic rdb,
                       input logic [4:0] ed, input logic ev, input logic ew,
                       input logic [4:0] md, input logic mv, input logic mw,
                       input logic bi, input logic be, input logic t,
                       input logic [1:0] ei, input logic [1:0] eid, input logic [1:0] eex,
                       input string tag);
    @(posedge clk); #1;
    src_a = a; src_b = b; rb = rdb;
    exd = ed; exv = ev; exw = ew;
    memd = md; memv = mv; memw = mw;
    bid = bi; bex = be; tk = t;
    exp_q.push_back({ei, eid, eex, XF, XF});
    tag_q.push_back(tag);
  endtask

  task automatic check_cost(input int exp_cnt, input string tag);
    @(negedge clk); #1;
    compared++;
    if (id_bubbles != exp_cnt) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d decode bubbles", tag, id_bubbles, exp_cnt);
    end
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 idle / reset-like state
    drive(0,0,0, 0,0,0, 0,0,0, 0,0,0, XF,XF,XF, "R1 idle");
    drive(3,4,1, 5,1,1, 6,1,1, 0,0,0, XF,XF,XF, "R1 no match");
    drive(7,0,0, 7,1,1, 0,0,0, 0,0,0, HD,HD,BB, "R2 A vs EX");
    drive(9,0,0, 0,0,0, 9,1,1, 0,0,0, HD,HD,BB, "R3 A vs MEM");
    drive(1,12,1, 12,1,1, 0,0,0, 0,0,0, HD,HD,BB, "R4 B used");
    drive(1,12,0, 12,1,1, 12,1,1, 0,0,0, XF,XF,XF, "R4 B ignored");
    drive(1,14,1, 0,0,0, 14,1,1, 0,0,0, HD,HD,BB, "R3 B vs MEM");
    drive(31,31,1, 31,1,1, 31,1,1, 0,0,0, XF,XF,XF, "R5 zero reg");
    drive(8,8,1, 8,0,1, 8,1,0, 0,0,0, XF,XF,XF, "R6 not live");
    drive(8,0,0, 8,1,0, 8,0,1, 0,0,0, XF,XF,XF, "R6 not live 2");
    drive(2,0,0, 0,0,0, 0,0,0, 1,0,0, HD,BB,XF, "R7 br in ID");
    drive(2,0,0, 0,0,0, 0,0,0, 0,1,0, HD,BB,XF, "R7 br in EX");
    drive(4,0,0, 4,1,1, 0,0,0, 1,0,0, HD,HD,BB, "R10 hazard over branch");
    drive(4,0,0, 4,1,1, 4,1,1, 1,1,1, XF,BB,XF, "R8 taken overrides");
    drive(3,0,0, 0,0,0, 0,0,0, 0,0,0, XF,XF,XF, "R9 not taken flows");
    drive(0,0,0, 0,0,0, 0,0,0, 0,0,0, XF,XF,XF, "R11 idle");
    @(negedge clk); #1;

    // R9 cost: taken branch, three decode bubbles
    id_bubbles = 0;
    drive(0,0,0, 0,0,0, 0,0,0, 1,0,0, HD,BB,XF, "R9 taken step1");
    drive(0,0,0, 0,0,0, 0,0,0, 0,1,0, HD,BB,XF, "R9 taken step2");
    drive(0,0,0, 0,0,0, 0,0,0, 0,0,1, XF,BB,XF, "R9 taken step3");
    check_cost(3, "R9 taken cost");
    // R9 cost: not-taken branch, two decode bubbles
    id_bubbles = 0;
    drive(0,0,0, 0,0,0, 0,0,0, 1,0,0, HD,BB,XF, "R9 nt step1");
    drive(0,0,0, 0,0,0, 0,0,0, 0,1,0, HD,BB,XF, "R9 nt step2");
    drive(0,0,0, 0,0,0, 0,0,0, 0,0,0, XF,XF,XF, "R9 nt step3");
    check_cost(2, "R9 not-taken cost");

    @(negedge clk); #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule